// File: doc/BRIEF.md
# Dual-Read Register File with Hardwired Zero Entry

This block holds a bank of general-purpose data words for a datapath. It has two read ports and one write port. Each read port takes an entry index and shows that entry's contents on its data output through combinational logic. Both read ports work at the same time and do not affect each other. The write port has a destination index, a data word and a write enable. It changes state only on the rising clock edge.

Entry zero has no storage. It always reads as all zeros, so software can use it as a constant source and as a place to discard results. A one-hot load decoder, gated by the write enable, picks the entry that captures data. Every other entry recirculates its own value through a hold selector in front of its flip-flops. Because of this, movement on the enable between clock edges cannot disturb stored data. An asynchronous active-low reset clears every entry.

Top module: `rf_dual_read`

## Requirements
- R1: When `wr_en` is high at a rising edge of `clk` and `wr_sel` is nonzero, entry `wr_sel` takes the value of `wr_data`. The bank has 32 entries of 32 bits each, selected by 5-bit indices.
- R2: `rd_data_a` shows the contents of the entry chosen by `rd_sel_a` in the same cycle, with no clock edge needed.
- R3: `rd_data_b` shows the contents of the entry chosen by `rd_sel_b`. It does not depend on `rd_sel_a`.
- R4: Index 0 reads as 32'h0 on both ports at all times. A write to index 0 has no visible effect.
- R5: When `wr_en` is low at a rising edge, no entry changes.
- R6: Pulses on `wr_en` that begin and end between rising edges change no entry.
- R7: A read of the index being written returns the old contents until the rising edge and the new contents after it. Write data is not forwarded to the read ports.
- R8: A write changes only the addressed entry. Every other entry keeps its contents.
- R9: While `rst_n` is low, every entry is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_a | input | 5 | Index for read port A |
| rd_data_a | output | 32 | Contents of the entry selected on port A |
| rd_sel_b | input | 5 | Index for read port B |
| rd_data_b | output | 32 | Contents of the entry selected on port B |
| wr_sel | input | 5 | Destination index for a write |
| wr_data | input | 32 | Data word to write |
| wr_en | input | 1 | Write enable, sampled at the rising edge |

## Verification
A read and a write can target the same entry in one cycle. The bench provokes this by pointing a read port at the index being written while `wr_en` is high. It then compares the port against the reference value just before the edge, where the old word is expected, and just after it, where the new word is expected. Enable pulses placed wholly inside the low and high clock phases are judged the same way: the addressed entry must read back unchanged.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_DEPTH = 32;
  parameter int unsigned RF_WIDTH = 32;
endpackage

// File: rtl/rf_load_decoder.sv
// Enabled one-hot decoder for the load strobes. Entry 0 has no storage,
// so no strobe is produced for it.
module rf_load_decoder #(
  parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_sel,
  output logic [DEPTH-1:1] load
);
  for (genvar i = 1; i < DEPTH; i++) begin : g_dec
    assign load[i] = wr_en & (wr_sel == IDX_W'(i));
  end
endmodule

// File: rtl/rf_word.sv
// One storage word: a hold selector in front of the flip-flops, with an
// asynchronous clear.
module rf_word #(
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/rf_read_mux.sv
// Read selector built bit by bit: each output bit is its own
// DEPTH-to-1 selection over one bit column of the bank.
module rf_read_mux #(
  parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] bank,
  input  logic [IDX_W-1:0]            sel,
  output logic [WIDTH-1:0]            dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [DEPTH-1:0] column;
    for (genvar e = 0; e < DEPTH; e++) begin : g_col
      assign column[e] = bank[e][b];
    end
    assign dout[b] = column[sel];
  end
endmodule

// File: rtl/rf_dual_read.sv
module rf_dual_read #(
  parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_sel_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [IDX_W-1:0] rd_sel_b,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic [IDX_W-1:0] wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en
);
  logic [DEPTH-1:1]            load;
  logic [DEPTH-1:0][WIDTH-1:0] bank;

  rf_load_decoder #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .load   (load)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    if (e == 0) begin : g_zero
      // Constant zero feeds both selectors; there are no flip-flops here.
      assign bank[e] = '0;
    end else begin : g_store
      rf_word #(.WIDTH(WIDTH)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load[e]),
        .d     (wr_data),
        .q     (bank[e])
      );
    end
  end

  rf_read_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_rd_a (
    .bank (bank),
    .sel  (rd_sel_a),
    .dout (rd_data_a)
  );

  rf_read_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_rd_b (
    .bank (bank),
    .sel  (rd_sel_b),
    .dout (rd_data_b)
  );
endmodule

// File: rtl/rf_dual_read_chk.sv
module rf_dual_read_chk #(
  parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] rd_sel_a,
  input logic [WIDTH-1:0] rd_data_a,
  input logic [IDX_W-1:0] rd_sel_b,
  input logic [WIDTH-1:0] rd_data_b,
  input logic [IDX_W-1:0] wr_sel,
  input logic [WIDTH-1:0] wr_data,
  input logic             wr_en
);
  // R4
  zero_port_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_a == '0) |-> (rd_data_a == '0));

  // R4
  zero_port_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_b == '0) |-> (rd_data_b == '0));

  // R1
  write_lands_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_sel) != '0) && (rd_sel_a == $past(wr_sel)))
      |-> (rd_data_a == $past(wr_data)));

  // R1
  write_lands_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_sel) != '0) && (rd_sel_b == $past(wr_sel)))
      |-> (rd_data_b == $past(wr_data)));

  // R5
  idle_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(rd_sel_a)) |-> $stable(rd_data_a));

  // R5
  idle_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(rd_sel_b)) |-> $stable(rd_data_b));

  // R8
  other_entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(rd_sel_a) && ($past(wr_sel) != rd_sel_a)) |-> $stable(rd_data_a));
endmodule

bind rf_dual_read rf_dual_read_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_sel_a  (rd_sel_a),
  .rd_data_a (rd_data_a),
  .rd_sel_b  (rd_sel_b),
  .rd_data_b (rd_data_b),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .wr_en     (wr_en)
);

// File: tb/sim_rf_dual_read.sv
`timescale 1ns/1ps
module sim_rf_dual_read;
  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int IW    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IW-1:0]    rd_sel_a = '0, rd_sel_b = '0, wr_sel = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] rd_data_a, rd_data_b;

  logic [WIDTH-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rf_dual_read u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_en(wr_en)
  );

  function automatic logic [WIDTH-1:0] expect_at(input int idx);
    return (idx == 0) ? '0 : model[idx];
  endfunction

  task automatic compare(input string req, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_both(input int a, input int b, input string req);
    rd_sel_a = IW'(a);
    rd_sel_b = IW'(b);
    #2;
    compare(req, rd_data_a, expect_at(a));
    compare(req, rd_data_b, expect_at(b));
  endtask

  task automatic do_write(input int idx, input logic [WIDTH-1:0] val);
    @(negedge clk);
    wr_sel = IW'(idx); wr_data = val; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx != 0) model[idx] = val;
  endtask

  // R9: cleared by reset
  task automatic t_reset;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    for (int i = 0; i < DEPTH; i += 4) read_both(i, DEPTH - 1 - i, "R9 reset clear");
    @(negedge clk); rst_n = 1'b1;
  endtask

  // R1 R2 R3: fill the bank, read back on both ports in differing orders
  task automatic t_fill_and_read;
    for (int i = 0; i < DEPTH; i++) do_write(i, 32'hA5000000 ^ (i * 32'h01010101) ^ (i << 20));
    for (int i = 0; i < DEPTH; i++) read_both(i, (i * 7 + 3) % DEPTH, "R2 R3 readback");
    for (int i = 0; i < DEPTH; i++) read_both(DEPTH - 1 - i, i, "R1 stored value");
  endtask

  // R4: writes to index zero leave it reading zero
  task automatic t_zero;
    do_write(0, 32'hFFFF_FFFF);
    read_both(0, 0, "R4 zero entry");
    do_write(0, 32'h1234_5678);
    read_both(0, 1, "R4 zero entry");
  endtask

  // R5: enable low at the edge with live data and index
  task automatic t_idle;
    @(negedge clk);
    wr_sel = 5'd9; wr_data = 32'hDEAD_BEEF; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    read_both(9, 10, "R5 idle edge");
  endtask

  // R6: enable pulses inside both clock phases, never spanning an edge
  task automatic t_glitch;
    @(negedge clk);
    wr_sel = 5'd5; wr_data = 32'h0BAD_F00D;
    #2 wr_en = 1'b1; #2 wr_en = 1'b0;
    #1 wr_en = 1'b1; #2 wr_en = 1'b0;
    @(posedge clk);
    #2 wr_en = 1'b1; #3 wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    read_both(5, 5, "R6 glitch ignored");
  endtask

  // R7: read and write of the same entry in one cycle
  task automatic t_same_cycle;
    @(negedge clk);
    rd_sel_a = 5'd17; rd_sel_b = 5'd18;
    wr_sel = 5'd17; wr_data = 32'h7777_1111; wr_en = 1'b1;
    #2;
    compare("R7 old before edge", rd_data_a, model[17]);
    @(posedge clk); #2;
    model[17] = 32'h7777_1111;
    compare("R7 new after edge", rd_data_a, model[17]);
    compare("R3 other port unaffected", rd_data_b, model[18]);
    @(negedge clk); wr_en = 1'b0;
  endtask

  // R8: one write leaves every other entry intact
  task automatic t_isolation;
    do_write(22, 32'hCAFE_0022);
    for (int i = 0; i < DEPTH; i++) read_both(i, i, "R8 isolation");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35;
    t_reset();
    t_fill_and_read();
    t_zero();
    t_idle();
    t_glitch();
    t_same_cycle();
    t_isolation();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule